// File: doc/BRIEF.md
# Vectored Block-Transfer DMA Engine

This engine copies data between two memory regions without processor involvement. When it is started, it finds its working parameters indirectly. A vector number selects a 16-bit entry in a table located at a fixed base. That entry points to a five-word descriptor in memory. The descriptor holds a mode word, a source address, a destination address and two counters. The engine fetches the descriptor and performs the copy over a single-master memory bus. It then stores the updated addresses and counters back into the descriptor, so the next activation continues where this one stopped.

A transfer can be started in two ways. A peripheral can hold a request line high and present a vector. Software can write a one-byte control register that carries a start bit and a vector number. Each hardware activation ends with one of two results. Either a flag-clear strobe goes back to the peripheral, or, once the count runs out, a disable strobe goes to the peripheral together with a processor interrupt. Each software activation ends with a completion interrupt. Software must then clear the start bit itself.

The bus completes every access in one cycle. During a write cycle it latches the write data. During a read cycle the read data is sampled at the clock edge that ends the cycle. Descriptor and vector-table accesses are little-endian 16-bit words.

Top module: `vdma_engine`

## Requirements
- R1: The first bus cycle of every activation is a word read at address 0x0400 + 2 × vector. The data returned is the descriptor base address.
- R2: The five descriptor words are then read in this order: base+0 mode, base+2 source, base+4 destination, base+6 count A, base+8 count B.
- R3: Mode bits [15:14] set the source address mode and bits [13:12] set the destination address mode. Code 2'b10 adds one unit after each access, 2'b11 subtracts one unit, and 2'b00 or 2'b01 leave the address unchanged.
- R4: Mode bit 8 selects the unit size. When it is 0, transfers are bytes: bus_byte is high, the step is 1 and the read data is zero-extended. When it is 1, transfers are 16-bit words: bus_byte is low and the step is 2.
- R5: Each unit takes one read cycle at the source address, followed directly by one write cycle that carries the read data to the destination address.
- R6: Mode bits [11:10] select the transfer mode. When they are 2'b10 (block mode), an activation moves count A[7:0] units, where a value of 0 means 256. At the end of the block, count A[7:0] is reloaded from count A[15:8] and count B is decremented by 1. In any other mode, an activation moves one unit and count A is decremented by 1.
- R7: After the last unit, the updated source address, destination address, count A and count B are written back to base+2, base+4, base+6 and base+8, in that order.
- R8: busy is high from the vector-table read through the last write-back cycle, and low at all other times. bus_req is never high while busy is low.
- R9: A hardware activation ends with a single one-cycle strobe cycle after the write-back. If the counter that governs completion has become 0 (count B in block mode, count A otherwise), hw_disable and cpu_irq pulse together. Otherwise hw_ack pulses.
- R10: The control register reads back on cpu_rdata: bit 7 is the start bit and bits [6:0] are the vector number. It resets to 0x00. An accepted write that sets bit 7 starts one software activation for that vector.
- R11: A write with bit 7 set is ignored while bit 7 of the control register is already set. A write with bit 7 clear is always accepted.
- R12: A software activation ends with a one-cycle swend_irq pulse one cycle after the write-back. The start bit stays set after this pulse.
- R13: When a hardware request and a pending software activation are both present in the idle state, the hardware request is served first. The software activation follows once the engine is idle again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 1 | Level request from a peripheral |
| hw_vec | input | 7 | Vector number that goes with hw_req |
| hw_ack | output | 1 | Strobe that clears the peripheral's request flag |
| hw_disable | output | 1 | Strobe that clears the peripheral's request enable when the count is exhausted |
| cpu_irq | output | 1 | Processor interrupt strobe when the count is exhausted |
| cpu_wr | input | 1 | Write strobe for the control register |
| cpu_wdata | input | 8 | Control write data: start bit 7, vector [6:0] |
| cpu_rdata | output | 8 | Control register value |
| swend_irq | output | 1 | Software activation complete strobe |
| busy | output | 1 | Activation in progress |
| bus_req | output | 1 | Bus cycle valid |
| bus_we | output | 1 | Bus cycle is a write |
| bus_byte | output | 1 | Bus cycle is byte-wide |
| bus_addr | output | 16 | Bus byte address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |

## Verification
Two functions can land in the same idle cycle: a peripheral raising its request and software writing a start command. The bench provokes this by driving both in the same clock. It then checks that the first bus cycle reads the peripheral's vector entry, and that the software transfer starts only after the hardware completion strobe and one idle cycle. A second collision is a start write that arrives while the start bit is still set. The bench judges this at the control read-back and at the bus, which must stay idle.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
    localparam int AW = 16;
    localparam int DW = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VEC,
        ST_FETCH,
        ST_RD,
        ST_WR,
        ST_WB,
        ST_DONE
    } st_e;

    localparam logic [1:0] AM_INC   = 2'b10;
    localparam logic [1:0] AM_DEC   = 2'b11;
    localparam logic [1:0] TM_BLOCK = 2'b10;

    localparam int SM_HI  = 15;
    localparam int DM_HI  = 13;
    localparam int TM_HI  = 11;
    localparam int SZ_BIT = 8;
endpackage

// File: rtl/vdma_addr_step.sv
module vdma_addr_step
    import vdma_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] addr_i,
    input  logic [1:0]       mode_i,
    input  logic             word_i,
    output logic [WIDTH-1:0] addr_o
);
    logic [WIDTH-1:0] step;

    always_comb begin
        step = word_i ? WIDTH'(2) : WIDTH'(1);
        case (mode_i)
            AM_INC:  addr_o = addr_i + step;
            AM_DEC:  addr_o = addr_i - step;
            default: addr_o = addr_i;
        endcase
    end
endmodule

// File: rtl/vdma_swreg.sv
module vdma_swreg #(
    parameter int VW = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [VW:0] wdata_i,
    input  logic        take_i,
    output logic [VW:0] q_o,
    output logic        pend_o
);
    typedef struct packed {
        logic [VW:0] r;
        logic        pend;
    } sw_t;

    sw_t q, d;

    always_comb begin
        d = q;
        if (take_i) begin
            d.pend = 1'b0;
        end
        if (wr_i && !(q.r[VW] && wdata_i[VW])) begin
            d.r    = wdata_i;
            d.pend = wdata_i[VW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign q_o    = q.r;
    assign pend_o = q.pend;
endmodule

// File: rtl/vdma_arb.sv
module vdma_arb (
    input  logic hw_req_i,
    input  logic sw_pend_i,
    output logic sel_hw_o,
    output logic sel_sw_o
);
    assign sel_hw_o = hw_req_i;
    assign sel_sw_o = sw_pend_i && !hw_req_i;
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
    import vdma_pkg::*;
#(
    parameter int            VW       = 7,
    parameter logic [AW-1:0] VEC_BASE = 16'h0400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_req,
    input  logic [VW-1:0] hw_vec,
    output logic          hw_ack,
    output logic          hw_disable,
    output logic          cpu_irq,
    input  logic          cpu_wr,
    input  logic [VW:0]   cpu_wdata,
    output logic [VW:0]   cpu_rdata,
    output logic          swend_irq,
    output logic          busy,
    output logic          bus_req,
    output logic          bus_we,
    output logic          bus_byte,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);
    localparam int IW         = 3;
    localparam int FETCH_LAST = 4;
    localparam int WB_LAST    = 3;
    localparam int NPTR       = 2;

    typedef struct packed {
        st_e           st;
        logic [IW-1:0] idx;
        logic          hw;
        logic          zero;
        logic [VW-1:0] vec;
        logic [AW-1:0] base;
        logic [AW-1:0] sar;
        logic [AW-1:0] dar;
        logic [DW-1:0] mode;
        logic [DW-1:0] cra;
        logic [DW-1:0] crb;
        logic [DW-1:0] data;
    } regs_t;

    regs_t q, d;

    logic          sel_hw, sel_sw, sw_pend, sw_take;
    logic [VW:0]   sw_q;
    logic          is_block, word, last;
    logic [DW-1:0] cra_dec, crb_dec;
    logic [NPTR-1:0][AW-1:0] step_in, step_out;
    logic [NPTR-1:0][1:0]    step_mode;

    vdma_swreg #(.VW(VW)) u_swreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cpu_wr),
        .wdata_i (cpu_wdata),
        .take_i  (sw_take),
        .q_o     (sw_q),
        .pend_o  (sw_pend)
    );

    vdma_arb u_arb (
        .hw_req_i  (hw_req),
        .sw_pend_i (sw_pend),
        .sel_hw_o  (sel_hw),
        .sel_sw_o  (sel_sw)
    );

    assign step_in   = {q.dar, q.sar};
    assign step_mode = {q.mode[DM_HI -: 2], q.mode[SM_HI -: 2]};

    generate
        for (genvar g = 0; g < NPTR; g++) begin : g_step
            vdma_addr_step #(.WIDTH(AW)) u_step (
                .addr_i (step_in[g]),
                .mode_i (step_mode[g]),
                .word_i (word),
                .addr_o (step_out[g])
            );
        end
    endgenerate

    assign is_block = (q.mode[TM_HI -: 2] == TM_BLOCK);
    assign word     = q.mode[SZ_BIT];
    assign cra_dec  = q.cra - DW'(1);
    assign crb_dec  = q.crb - DW'(1);

    always_comb begin
        d          = q;
        last       = 1'b0;
        sw_take    = 1'b0;
        bus_req    = 1'b0;
        bus_we     = 1'b0;
        bus_byte   = 1'b0;
        bus_addr   = '0;
        bus_wdata  = '0;
        hw_ack     = 1'b0;
        hw_disable = 1'b0;
        cpu_irq    = 1'b0;
        swend_irq  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (sel_hw) begin
                    d.st  = ST_VEC;
                    d.hw  = 1'b1;
                    d.vec = hw_vec;
                end else if (sel_sw) begin
                    d.st    = ST_VEC;
                    d.hw    = 1'b0;
                    d.vec   = sw_q[VW-1:0];
                    sw_take = 1'b1;
                end
            end
            ST_VEC: begin
                bus_req  = 1'b1;
                bus_addr = VEC_BASE + (AW'(q.vec) << 1);
                d.base   = bus_rdata;
                d.idx    = '0;
                d.st     = ST_FETCH;
            end
            ST_FETCH: begin
                bus_req  = 1'b1;
                bus_addr = q.base + (AW'(q.idx) << 1);
                case (q.idx)
                    3'd0:    d.mode = bus_rdata;
                    3'd1:    d.sar  = bus_rdata;
                    3'd2:    d.dar  = bus_rdata;
                    3'd3:    d.cra  = bus_rdata;
                    default: d.crb  = bus_rdata;
                endcase
                if (q.idx == IW'(FETCH_LAST)) begin
                    d.st = ST_RD;
                end else begin
                    d.idx = q.idx + IW'(1);
                end
            end
            ST_RD: begin
                bus_req  = 1'b1;
                bus_byte = !word;
                bus_addr = q.sar;
                d.data   = word ? bus_rdata : {8'h00, bus_rdata[7:0]};
                d.st     = ST_WR;
            end
            ST_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_byte  = !word;
                bus_addr  = q.dar;
                bus_wdata = q.data;
                d.sar     = step_out[0];
                d.dar     = step_out[1];
                if (is_block) begin
                    if (q.cra[7:0] == 8'd1) begin
                        d.cra[7:0] = q.cra[15:8];
                        d.crb      = crb_dec;
                        d.zero     = (crb_dec == '0);
                        last       = 1'b1;
                    end else begin
                        d.cra[7:0] = cra_dec[7:0];
                    end
                end else begin
                    d.cra  = cra_dec;
                    d.zero = (cra_dec == '0);
                    last   = 1'b1;
                end
                d.idx = '0;
                d.st  = last ? ST_WB : ST_RD;
            end
            ST_WB: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = q.base + (AW'(q.idx + IW'(1)) << 1);
                case (q.idx)
                    3'd0:    bus_wdata = q.sar;
                    3'd1:    bus_wdata = q.dar;
                    3'd2:    bus_wdata = q.cra;
                    default: bus_wdata = q.crb;
                endcase
                if (q.idx == IW'(WB_LAST)) begin
                    d.st = ST_DONE;
                end else begin
                    d.idx = q.idx + IW'(1);
                end
            end
            ST_DONE: begin
                if (q.hw) begin
                    if (q.zero) begin
                        hw_disable = 1'b1;
                        cpu_irq    = 1'b1;
                    end else begin
                        hw_ack = 1'b1;
                    end
                end else begin
                    swend_irq = 1'b1;
                end
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE) && (q.st != ST_DONE);
    assign cpu_rdata = sw_q;
endmodule

// File: rtl/vdma_engine_chk.sv
module vdma_engine_chk #(
    parameter int VW = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        bus_req,
    input logic        bus_we,
    input logic        bus_byte,
    input logic        hw_ack,
    input logic        hw_disable,
    input logic        cpu_irq,
    input logic        swend_irq,
    input logic        cpu_wr,
    input logic [VW:0] cpu_wdata,
    input logic [VW:0] cpu_rdata
);
    assert_bus_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy);

    assert_start_vector_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (bus_req && !bus_we && !bus_byte));

    assert_end_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_ack || hw_disable) |-> (!(hw_ack && hw_disable) && !busy));

    assert_irq_with_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_disable || cpu_irq) |-> (hw_disable && cpu_irq));

    assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ack |=> !hw_ack);

    assert_ignore_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_wdata[VW] && cpu_rdata[VW]) |=> (cpu_rdata == $past(cpu_rdata)));

    assert_swend_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        swend_irq |-> (cpu_rdata[VW] && !busy));
endmodule

bind vdma_engine vdma_engine_chk #(.VW(VW)) u_chk (.*);

// File: tb/vdma_engine_test.sv
module vdma_engine_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit        we;
        bit        byt;
        bit [15:0] addr;
        bit [15:0] data;
        string     tag;
    } txn_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_req = 1'b0;
    logic [6:0]  hw_vec = '0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [15:0] bus_rdata = '0;
    logic        hw_ack, hw_disable, cpu_irq, swend_irq, busy;
    logic        bus_req, bus_we, bus_byte;
    logic [7:0]  cpu_rdata;
    logic [15:0] bus_addr, bus_wdata;

    vdma_engine uut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hw_vec(hw_vec),
        .hw_ack(hw_ack), .hw_disable(hw_disable), .cpu_irq(cpu_irq),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .swend_irq(swend_irq), .busy(busy), .bus_req(bus_req), .bus_we(bus_we),
        .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] mem [int];
    txn_t expq[$];
    txn_t defq[$];
    txn_t scratch[$];
    logic [3:0] exp_pulse = '0;
    logic [3:0] def_pulse = '0;
    bit pend_done = 0;
    bit defer_cnt = 0;
    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    function automatic logic [7:0] rd8(int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic logic [15:0] rd16(int a);
        return {rd8(a + 1), rd8(a)};
    endfunction

    function automatic void set16(int a, logic [15:0] v);
        mem[a]     = v[7:0];
        mem[a + 1] = v[15:8];
    endfunction

    function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    function automatic void push(bit we, bit byt, logic [15:0] a, logic [15:0] dat, string tag);
        txn_t t;
        t.we = we; t.byt = byt; t.addr = a; t.data = dat; t.tag = tag;
        scratch.push_back(t);
    endfunction

    function automatic logic [15:0] adv(logic [15:0] a, logic [1:0] m, bit wd);
        logic [15:0] st;
        st = wd ? 16'd2 : 16'd1;
        case (m)
            2'b10:   return a + st;
            2'b11:   return a - st;
            default: return a;
        endcase
    endfunction

    // Reference: builds the expected bus cycles and end strobes from memory contents
    task automatic predict(input logic [6:0] vec, input bit hw, output logic [3:0] pulse);
        int entry, base, n;
        logic [15:0] mode, sar, dar, cra, crb, dat;
        bit blk, wd, zero;
        scratch.delete();
        entry = 'h400 + 2 * vec;
        push(0, 0, 16'(entry), 0, "R1 vector-table read");
        base = int'(rd16(entry));
        for (int i = 0; i < 5; i++) push(0, 0, 16'(base + 2 * i), 0, "R2 descriptor read");
        mode = rd16(base); sar = rd16(base + 2); dar = rd16(base + 4);
        cra = rd16(base + 6); crb = rd16(base + 8);
        blk = (mode[11:10] == 2'b10);
        wd  = mode[8];
        n = blk ? ((cra[7:0] == 8'd0) ? 256 : int'(cra[7:0])) : 1;
        for (int i = 0; i < n; i++) begin
            dat = wd ? rd16(int'(sar)) : {8'h00, rd8(int'(sar))};
            push(0, !wd, sar, 0, "R3 R4 R5 source read");
            push(1, !wd, dar, dat, "R3 R4 R5 destination write");
            sar = adv(sar, mode[15:14], wd);
            dar = adv(dar, mode[13:12], wd);
        end
        if (blk) begin
            cra  = {cra[15:8], cra[15:8]};
            crb  = crb - 16'd1;
            zero = (crb == 16'd0);
        end else begin
            cra  = cra - 16'd1;
            zero = (cra == 16'd0);
        end
        push(1, 0, 16'(base + 2), sar, "R7 source write-back");
        push(1, 0, 16'(base + 4), dar, "R7 destination write-back");
        push(1, 0, 16'(base + 6), cra, "R6 R7 count A write-back");
        push(1, 0, 16'(base + 8), crb, "R6 R7 count B write-back");
        pulse = hw ? (zero ? 4'b0110 : 4'b1000) : 4'b0001;
    endtask

    // Per-cycle comparison against the reference, plus the memory model
    txn_t t;
    always @(negedge clk) begin
        if (rst_n) begin
            if (expq.size() > 0) begin
                t = expq.pop_front();
                check({t.tag, " busy"}, 32'(busy), 32'd1);
                check({t.tag, " cycle kind"}, 32'({bus_req, bus_we, bus_byte}), 32'({1'b1, t.we, t.byt}));
                check({t.tag, " address"}, 32'(bus_addr), 32'(t.addr));
                if (t.we) check({t.tag, " data"}, 32'(bus_wdata), 32'(t.data));
                if (expq.size() == 0) pend_done = 1;
            end else if (pend_done) begin
                check("R9 R12 completion strobes", 32'({hw_ack, hw_disable, cpu_irq, swend_irq}), 32'(exp_pulse));
                check("R8 idle after write-back", 32'({busy, bus_req}), 32'd0);
                pend_done = 0;
                if (defq.size() > 0) defer_cnt = 1;
            end else begin
                check("R8 R9 R12 quiet while idle",
                      32'({busy, bus_req, hw_ack, hw_disable, cpu_irq, swend_irq}), 32'd0);
                if (defer_cnt) begin
                    expq = defq;
                    defq.delete();
                    exp_pulse = def_pulse;
                    defer_cnt = 0;
                end
            end
            if (bus_req && bus_we) begin
                mem[int'(bus_addr)] = bus_wdata[7:0];
                if (!bus_byte) mem[int'(bus_addr) + 1] = bus_wdata[15:8];
            end
            bus_rdata = !bus_req ? 16'h0000 :
                        bus_byte ? {8'h00, rd8(int'(bus_addr))} : rd16(int'(bus_addr));
        end
    end

    task automatic wait_idle();
        while (expq.size() != 0 || defq.size() != 0 || pend_done || defer_cnt) @(posedge clk);
    endtask

    task automatic hw_run(input logic [6:0] vec);
        logic [3:0] p;
        predict(vec, 1, p);
        @(posedge clk); #1;
        hw_vec = vec;
        hw_req = 1'b1;
        @(posedge clk); #1;
        expq = scratch;
        exp_pulse = p;
        wait_idle();
        #1 hw_req = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic sw_run(input logic [6:0] vec);
        logic [3:0] p;
        predict(vec, 0, p);
        @(posedge clk); #1;
        cpu_wdata = {1'b1, vec};
        cpu_wr = 1'b1;
        @(posedge clk); #1;
        cpu_wr = 1'b0;
        check("R10 start write read-back", 32'(cpu_rdata), 32'({1'b1, vec}));
        @(posedge clk); #1;
        expq = scratch;
        exp_pulse = p;
        wait_idle();
        repeat (2) @(posedge clk);
    endtask

    task automatic cpu_write(input logic [7:0] v);
        @(posedge clk); #1;
        cpu_wdata = v;
        cpu_wr = 1'b1;
        @(posedge clk); #1;
        cpu_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R8 watchdog: actual still running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        txn_t hwq[$];
        logic [3:0] ph, ps;

        // descriptors
        set16('h420, 16'h3000);
        set16('h3000, 16'hA000); set16('h3002, 16'h1100); set16('h3004, 16'h2100);
        set16('h3006, 16'h0003); set16('h3008, 16'h0000);
        for (int i = 0; i < 4; i++) mem['h1100 + i] = 8'(8'h50 + i);

        set16('h4C0, 16'h3100);
        set16('h3100, 16'hA800); set16('h3102, 16'h1000); set16('h3104, 16'h2000);
        set16('h3106, 16'h8080); set16('h3108, 16'h0001);
        for (int i = 0; i < 128; i++) mem['h1000 + i] = 8'(i * 3 + 1);

        set16('h40A, 16'h3200);
        set16('h3200, 16'hC900); set16('h3202, 16'h1410); set16('h3204, 16'h2400);
        set16('h3206, 16'h0303); set16('h3208, 16'h0002);
        set16('h1410, 16'hBEEF); set16('h140E, 16'h1234); set16('h140C, 16'hA5C3);

        set16('h444, 16'h3300);
        set16('h3300, 16'hA000); set16('h3302, 16'h1500); set16('h3304, 16'h2500);
        set16('h3306, 16'h0001); set16('h3308, 16'h0000);
        mem['h1500] = 8'h77;

        set16('h442, 16'h3400);
        set16('h3400, 16'hA000); set16('h3402, 16'h1600); set16('h3404, 16'h2600);
        set16('h3406, 16'h0005); set16('h3408, 16'h0000);
        mem['h1600] = 8'h99;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R10 R8 reset state", 32'({busy, bus_req, hw_ack, swend_irq, cpu_rdata}), 32'd0);

        // R9: three single-byte hardware activations, the third exhausts count A
        hw_run(7'h10);
        hw_run(7'h10);
        hw_run(7'h10);
        check("R6 count A after three activations", 32'(rd16('h3006)), 32'd0);

        // R6 R12: software block of 128 bytes
        sw_run(7'h60);
        check("R6 last byte of block", 32'(rd8('h207F)), 32'(8'(127 * 3 + 1)));
        check("R12 start bit held", 32'(cpu_rdata), 32'h0E0);

        // R11: start write while start bit is set is dropped
        cpu_write(8'hC5);
        check("R11 ignored start write", 32'(cpu_rdata), 32'h0E0);
        repeat (4) @(posedge clk);
        cpu_write(8'h00);
        check("R11 clearing write accepted", 32'(cpu_rdata), 32'h000);

        // R3 R4: word units, decrementing source, fixed destination, block of 3
        hw_run(7'h05);
        check("R4 word at fixed destination", 32'(rd16('h2400)), 32'hA5C3);
        check("R6 count B after block", 32'(rd16('h3208)), 32'h0001);

        // R13: hardware and software in the same cycle
        predict(7'h22, 1, ph);
        hwq = scratch;
        predict(7'h21, 0, ps);
        defq = scratch;
        def_pulse = ps;
        @(posedge clk); #1;
        cpu_wdata = 8'hA1;
        cpu_wr = 1'b1;
        hw_vec = 7'h22;
        hw_req = 1'b1;
        @(posedge clk); #1;
        cpu_wr = 1'b0;
        expq = hwq;
        exp_pulse = ph;
        check("R13 hardware served first", 32'(bus_addr), 32'h0444);
        while (expq.size() != 0 || pend_done) @(posedge clk);
        #1 hw_req = 1'b0;
        wait_idle();
        repeat (3) @(posedge clk);
        check("R13 software byte moved afterwards", 32'(rd8('h2600)), 32'h099);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        finished = 1;
        $finish;
    end
endmodule